// File: doc/BRIEF.md
# Serial Flash Read Controller

This block is the host side of a serial flash read path. A requester presents a start address, a byte count and a read mode. The block then opens one chip-select window and produces the serial clock by dividing the system clock. It sends the command byte and the 24-bit address, and leaves the correct idle gap before data. It then collects the returned bits into bytes and hands them out on a valid/ready stream. Three read modes exist: a plain read with no gap, a faster read with eight idle clocks, and a two-pin read. In the two-pin read the address and the data both move two bits per clock, and the controller hands the pins over to the flash before data starts.

The serial clock idles low. The controller changes its pin outputs only on falling clock edges and samples the returned data on rising edges. A transaction streams as many consecutive bytes as were asked for. It ends by raising chip select after the final bit. If the consumer stalls, the serial clock is parked low at a byte boundary while chip select stays asserted. The stream resumes where it stopped.

Top module: `spi_flash_rd`

## Requirements
- R1: After reset and whenever no transaction is active, `spi_cs_n` is 1, `spi_sclk` is 0, both output enables are 0, `busy` is 0 and `dout_valid` is 0.
- R2: The first 8 serial clocks carry the command on `spi_io0_o`, most significant bit first, with `spi_io0_oe`=1 and `spi_io1_oe`=0. The command is 8'h03 for `req_mode`=0 (plain), 8'h0B for 1 (fast), 8'hBB for 2 (two-pin) and 8'h03 for the spare code 3.
- R3: The 24-bit address follows, most significant bit first. In modes 0, 1 and 3 it takes 24 clocks on `spi_io0_o`. In mode 2 it takes 12 clocks with both pins driven, and `spi_io1_o` carries the higher bit of each pair.
- R4: Mode 1 inserts 8 idle clocks after the address, with `spi_io0_oe` held at 1. Modes 0 and 3 insert none. Mode 2 inserts 4.
- R5: In mode 2, both output enables drop on the falling edge that ends the last address clock and stay 0 until chip select rises.
- R6: `spi_sclk` is 0 whenever `spi_cs_n` is 1. Pin outputs and enables never change while `spi_sclk` is high.
- R7: Data is sampled on rising edges and assembled most significant bit first. Single-pin modes take one bit per clock from `spi_io1_i`. Mode 2 takes two bits per clock, with `spi_io1_i` as the higher bit. Bytes leave in address order, and a byte held with `dout_ready`=0 stays stable.
- R8: One request of `req_len_m1`+1 bytes uses exactly one chip-select window. That window holds exactly command + address + idle + data clocks, and chip select rises after the last data clock.
- R9: Chip select stays high for at least 2*DIV_HALF system clocks between transactions.
- R10: The first rising edge of a new byte is never issued while the output stage holds a byte that is not being accepted. The clock waits low, with chip select kept low.
- R11: `busy` is 1 from acceptance until the chip-select high time of R9 has elapsed. `req_ready` is its inverse, and a request offered while busy is dropped.
- R12: A span that crosses address 24'hFFFFFF is read in one window from one address. The bytes continue from address 0, because the flash wraps its counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken (not busy) |
| req_mode | input | 2 | 0 plain, 1 fast, 2 two-pin, 3 spare (plain) |
| req_addr | input | ADDR_W | Start address |
| req_len_m1 | input | LEN_W | Number of bytes minus one |
| busy | output | 1 | Transaction in progress |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_io0_o | output | 1 | Pin 0 output value |
| spi_io0_oe | output | 1 | Pin 0 output enable |
| spi_io0_i | input | 1 | Pin 0 input value |
| spi_io1_o | output | 1 | Pin 1 output value |
| spi_io1_oe | output | 1 | Pin 1 output enable |
| spi_io1_i | input | 1 | Pin 1 input value |
| dout_valid | output | 1 | Byte available |
| dout_ready | input | 1 | Consumer takes byte |
| dout_data | output | 8 | Received byte |

## Verification
A wrong phase counter or a wrong mode latch shows up on the pins within the same transaction. The flash model sees a bad command byte by clock 8 and a bad address by clock 32 (clock 20 in two-pin mode). A miscounted idle phase or a bad bit-pair order shows up as wrong bytes at the first stream handshake. A wrong byte count shows up at the chip-select rise as a clock total that does not match. A fault in the stall or hand-off logic shows up either at the first rising edge of a byte issued while the output was still held, or as a pin still enabled during the two-pin idle clocks. Because of this, each check fires within a few serial clocks of the faulty internal state.

// File: rtl/spi_rd_pkg.sv
// Shared types and constants for the serial flash read controller.
// Assumes a 24-bit address space on the flash side.
package spi_rd_pkg;

    typedef enum logic [1:0] {
        RD_PLAIN = 2'd0,
        RD_FAST  = 2'd1,
        RD_DUAL  = 2'd2,
        RD_SPARE = 2'd3
    } rd_mode_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_DUMMY,
        PH_DATA,
        PH_GAP
    } phase_e;

    localparam int CMD_CLOCKS       = 8;
    localparam int FAST_IDLE_CLOCKS = 8;
    localparam int DUAL_IDLE_CLOCKS = 4;

    localparam logic [7:0] OPC_PLAIN = 8'h03;
    localparam logic [7:0] OPC_FAST  = 8'h0B;
    localparam logic [7:0] OPC_DUAL  = 8'hBB;

    // Command byte sent for a given read mode.
    function automatic logic [7:0] opcode_for(rd_mode_e m);
        case (m)
            RD_FAST: return OPC_FAST;
            RD_DUAL: return OPC_DUAL;
            default: return OPC_PLAIN;
        endcase
    endfunction

endpackage

// File: rtl/spi_rd_clkgen.sv
// Half-period tick generator for the serial clock.
// Produces a one-cycle tick every DIV_HALF system clocks while run is high;
// the counter restarts from zero whenever run is low.
module spi_rd_clkgen #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt;

    // Count system clocks within one half period of the serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

endmodule

// File: rtl/spi_rd_bytecap.sv
// Byte assembler and one-entry output stage.
// Shifts in one bit (single pin) or two bits (two-pin, pin 1 higher) per
// sample strobe; on the strobe that closes a byte, the completed byte is
// loaded into the output stage. Assumes the sequencer never closes a byte
// while the output stage is occupied (it stalls at byte starts instead).
module spi_rd_bytecap (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample,
    input  logic       last,
    input  logic       dual,
    input  logic       io0_i,
    input  logic       io1_i,
    input  logic       out_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       slot_free
);
    logic [7:0] sh;
    logic [7:0] nxt;

    // Next shift value for the current pin width.
    always_comb begin
        if (dual) nxt = {sh[5:0], io1_i, io0_i};
        else      nxt = {sh[6:0], io1_i};
    end

    // Capture shift register, advanced on each sampling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      sh <= '0;
        else if (sample) sh <= nxt;
    end

    // Output stage: load a completed byte, release it on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (sample && last) begin
            out_valid <= 1'b1;
            out_data  <= nxt;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    assign slot_free = !out_valid || out_ready;

endmodule

// File: rtl/spi_rd_seq.sv
// Phase sequencer: command, address, idle clocks, data, and chip-select gap.
// Drives chip select, the serial clock and the pin outputs. Outputs change only
// on falling-edge ticks (or at acceptance, with the clock low); sampling is
// requested on rising-edge ticks. Assumes tick comes from spi_rd_clkgen.
module spi_rd_seq
    import spi_rd_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_fire,
    input  rd_mode_e          req_mode,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len_m1,
    input  logic              tick,
    input  logic              slot_free,
    output logic              run,
    output logic              sample,
    output logic              byte_last,
    output logic              dual,
    output logic              busy,
    output logic              cs_n,
    output logic              sclk,
    output logic              io0_o,
    output logic              io0_oe,
    output logic              io1_o,
    output logic              io1_oe
);
    localparam int SR_W = 8 + ADDR_W;
    localparam int CC_W = $clog2(ADDR_W + 1);

    phase_e            ph;
    logic              dual_q, fast_q, gap_half, sclk_q, cs_q;
    logic [SR_W-1:0]   sr;
    logic [CC_W-1:0]   ccnt, plen;
    logic [LEN_W-1:0]  left;
    logic              active, stall, rise_go, fall_go, phase_end;

    // Number of serial clocks in the current phase.
    always_comb begin
        case (ph)
            PH_ADDR:  plen = dual_q ? CC_W'(ADDR_W / 2) : CC_W'(ADDR_W);
            PH_DUMMY: plen = dual_q ? CC_W'(DUAL_IDLE_CLOCKS) : CC_W'(FAST_IDLE_CLOCKS);
            PH_DATA:  plen = dual_q ? CC_W'(4) : CC_W'(8);
            default:  plen = CC_W'(CMD_CLOCKS);
        endcase
    end

    assign active    = (ph == PH_CMD) || (ph == PH_ADDR) || (ph == PH_DUMMY) || (ph == PH_DATA);
    assign stall     = (ph == PH_DATA) && (ccnt == '0) && !slot_free;
    assign rise_go   = tick && active && !sclk_q && !stall;
    assign fall_go   = tick && active && sclk_q;
    assign phase_end = (ccnt == plen);

    // Phase, clock, chip select, shift and count state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph       <= PH_IDLE;
            dual_q   <= 1'b0;
            fast_q   <= 1'b0;
            gap_half <= 1'b0;
            sclk_q   <= 1'b0;
            cs_q     <= 1'b1;
            sr       <= '0;
            ccnt     <= '0;
            left     <= '0;
        end else if (ph == PH_IDLE) begin
            if (req_fire) begin
                ph     <= PH_CMD;
                cs_q   <= 1'b0;
                sr     <= {opcode_for(req_mode), req_addr};
                ccnt   <= '0;
                left   <= req_len_m1;
                dual_q <= (req_mode == RD_DUAL);
                fast_q <= (req_mode == RD_FAST);
            end
        end else if (ph == PH_GAP) begin
            if (tick) begin
                if (gap_half) ph <= PH_IDLE;
                else          gap_half <= 1'b1;
            end
        end else if (rise_go) begin
            sclk_q <= 1'b1;
            ccnt   <= ccnt + 1'b1;
        end else if (fall_go) begin
            sclk_q <= 1'b0;
            if (phase_end) begin
                ccnt <= '0;
                sr   <= sr << 1;
                case (ph)
                    PH_CMD:   ph <= PH_ADDR;
                    PH_ADDR:  ph <= (dual_q || fast_q) ? PH_DUMMY : PH_DATA;
                    PH_DUMMY: ph <= PH_DATA;
                    default: begin
                        if (left == '0) begin
                            cs_q     <= 1'b1;
                            ph       <= PH_GAP;
                            gap_half <= 1'b0;
                        end else begin
                            left <= left - 1'b1;
                        end
                    end
                endcase
            end else if (dual_q && ph == PH_ADDR) begin
                sr <= sr << 2;
            end else begin
                sr <= sr << 1;
            end
        end
    end

    assign run       = (ph != PH_IDLE);
    assign busy      = (ph != PH_IDLE);
    assign sample    = rise_go && (ph == PH_DATA);
    assign byte_last = (ccnt == plen - 1'b1);
    assign dual      = dual_q;
    assign cs_n      = cs_q;
    assign sclk      = sclk_q;
    assign io0_o     = (dual_q && ph == PH_ADDR) ? sr[SR_W-2] : sr[SR_W-1];
    assign io1_o     = dual_q && (ph == PH_ADDR) && sr[SR_W-1];
    assign io0_oe    = (ph == PH_CMD) || (ph == PH_ADDR) ||
                       (!dual_q && (ph == PH_DUMMY || ph == PH_DATA));
    assign io1_oe    = dual_q && (ph == PH_ADDR);

endmodule

// File: rtl/spi_flash_rd.sv
// Top level of the serial flash read controller.
// Accepts one request at a time (start address, byte count minus one, mode),
// runs the serial transaction and streams received bytes out. Assumes the
// flash changes its data on falling edges of the serial clock.
module spi_flash_rd
    import spi_rd_pkg::*;
#(
    parameter int DIV_HALF = 2,
    parameter int ADDR_W   = 24,
    parameter int LEN_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_mode,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len_m1,
    output logic              busy,
    output logic              spi_cs_n,
    output logic              spi_sclk,
    output logic              spi_io0_o,
    output logic              spi_io0_oe,
    input  logic              spi_io0_i,
    output logic              spi_io1_o,
    output logic              spi_io1_oe,
    input  logic              spi_io1_i,
    output logic              dout_valid,
    input  logic              dout_ready,
    output logic [7:0]        dout_data
);
    logic run, tick, sample, byte_last, dual, slot_free, req_fire;

    assign req_ready = !busy;
    assign req_fire  = req_valid && req_ready;

    spi_rd_clkgen #(.DIV_HALF(DIV_HALF)) u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    spi_rd_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_fire   (req_fire),
        .req_mode   (rd_mode_e'(req_mode)),
        .req_addr   (req_addr),
        .req_len_m1 (req_len_m1),
        .tick       (tick),
        .slot_free  (slot_free),
        .run        (run),
        .sample     (sample),
        .byte_last  (byte_last),
        .dual       (dual),
        .busy       (busy),
        .cs_n       (spi_cs_n),
        .sclk       (spi_sclk),
        .io0_o      (spi_io0_o),
        .io0_oe     (spi_io0_oe),
        .io1_o      (spi_io1_o),
        .io1_oe     (spi_io1_oe)
    );

    spi_rd_bytecap u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample    (sample),
        .last      (byte_last),
        .dual      (dual),
        .io0_i     (spi_io0_i),
        .io1_i     (spi_io1_i),
        .out_ready (dout_ready),
        .out_valid (dout_valid),
        .out_data  (dout_data),
        .slot_free (slot_free)
    );

endmodule

// File: rtl/spi_flash_rd_chk.sv
// Port-level protocol checker for spi_flash_rd, attached with bind.
module spi_flash_rd_chk #(
    parameter int DIV_HALF = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       busy,
    input logic       spi_cs_n,
    input logic       spi_sclk,
    input logic       spi_io0_o,
    input logic       spi_io0_oe,
    input logic       spi_io1_o,
    input logic       spi_io1_oe,
    input logic       dout_valid,
    input logic       dout_ready,
    input logic [7:0] dout_data
);
    localparam int GAP_MIN = 2 * DIV_HALF;
    localparam int GW      = $clog2(GAP_MIN + 1) + 1;

    logic [GW-1:0] gap_cnt;

    // Count system clocks with chip select high, saturating at the minimum.
    always_ff @(posedge clk) begin
        if (!rst_n)                          gap_cnt <= GW'(GAP_MIN);
        else if (!spi_cs_n)                  gap_cnt <= '0;
        else if (gap_cnt < GW'(GAP_MIN))     gap_cnt <= gap_cnt + 1'b1;
    end

    p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> (!spi_io0_oe && !spi_io1_oe));

    p_sclk_low_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    p_pins_steady_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |->
        ($stable(spi_io0_o) && $stable(spi_io0_oe) && $stable(spi_io1_o) && $stable(spi_io1_oe)));

    p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout_data)));

    p_cs_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> (gap_cnt >= GW'(GAP_MIN)));

    p_busy_window_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> busy);

    p_refuse_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

endmodule

bind spi_flash_rd spi_flash_rd_chk #(.DIV_HALF(DIV_HALF)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .busy       (busy),
    .spi_cs_n   (spi_cs_n),
    .spi_sclk   (spi_sclk),
    .spi_io0_o  (spi_io0_o),
    .spi_io0_oe (spi_io0_oe),
    .spi_io1_o  (spi_io1_o),
    .spi_io1_oe (spi_io1_oe),
    .dout_valid (dout_valid),
    .dout_ready (dout_ready),
    .dout_data  (dout_data)
);

// File: tb/spi_flash_rd_tb.sv
// Bench: behavioural flash model reacting to serial clock edges, an expected
// byte queue and per-clock protocol comparison.
module spi_flash_rd_tb;
    localparam int DH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_mode = 2'd0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_len_m1 = '0;
    logic        busy, spi_cs_n, spi_sclk;
    logic        spi_io0_o, spi_io0_oe, spi_io1_o, spi_io1_oe;
    logic        spi_io0_i = 1'b0;
    logic        spi_io1_i = 1'b0;
    logic        dout_valid;
    logic        dout_ready = 1'b1;
    logic [7:0]  dout_data;

    always #5 clk = ~clk;

    spi_flash_rd #(.DIV_HALF(DH)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_mode(req_mode), .req_addr(req_addr), .req_len_m1(req_len_m1),
        .busy(busy), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_io0_o(spi_io0_o), .spi_io0_oe(spi_io0_oe), .spi_io0_i(spi_io0_i),
        .spi_io1_o(spi_io1_o), .spi_io1_oe(spi_io1_oe), .spi_io1_i(spi_io1_i),
        .dout_valid(dout_valid), .dout_ready(dout_ready), .dout_data(dout_data)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [23:0] a);
        return a[7:0] ^ {a[14:8], a[15]} ^ {a[19:16], a[23:20]} ^ 8'h3C;
    endfunction

    // Current transaction as seen by the flash model.
    int          cur_mode = 0;
    logic [23:0] cur_addr = '0;
    int          cur_len = 0;
    int          ntx_exp = 0;
    logic [7:0]  exp_q[$];

    function automatic bit is_dual(input int m); return m == 2; endfunction
    function automatic int addr_clks(input int m); return is_dual(m) ? 12 : 24; endfunction
    function automatic int hdr_clks(input int m);
        return 8 + addr_clks(m) + (m == 1 ? 8 : (m == 2 ? 4 : 0));
    endfunction
    function automatic int bpb(input int m); return is_dual(m) ? 4 : 8; endfunction
    function automatic logic [7:0] exp_opc(input int m);
        return (m == 1) ? 8'h0B : ((m == 2) ? 8'hBB : 8'h03);
    endfunction

    // Monitor and flash model state.
    int          cyc = 0;
    int          nr = 0;
    int          gap = 1000;
    int          txn = 0;
    logic [7:0]  opc = '0;
    logic [23:0] arx = '0;
    bit          prev_cs = 1'b1;
    bit          prev_sclk = 1'b0;
    bit          prev_vnr = 1'b0;
    bit          bp_on = 1'b0;
    bit          done = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
            summary();
            $finish;
        end
        if (rst_n) begin
            // Consumer readiness for the coming edge.
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            dout_ready = bp_on ? (lfsr[0] & lfsr[3]) : 1'b1;
            // Per-clock protocol comparison.
            chk(!(spi_cs_n && spi_sclk), "R6 clock idles low", spi_sclk, 0);
            chk(spi_cs_n || busy, "R11 busy during window", busy, 1);
            chk(req_ready == !busy, "R11 ready is not busy", req_ready, !busy);
            if (spi_cs_n) chk(!spi_io0_oe && !spi_io1_oe, "R1 pins released", {spi_io1_oe, spi_io0_oe}, 0);
            // Output stream against the expected queue.
            if (dout_valid && dout_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected byte", dout_data, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(dout_data == e, "R7 byte value", dout_data, e);
                end
            end
            // Chip-select edges.
            if (prev_cs && !spi_cs_n) begin
                chk(gap >= 2 * DH, "R9 chip select high time", gap, 2 * DH);
                nr = 0; opc = '0; arx = '0; txn++;
            end
            if (!prev_cs && spi_cs_n) begin
                chk(nr == hdr_clks(cur_mode) + (cur_len + 1) * bpb(cur_mode),
                    "R8 clocks in window", nr, hdr_clks(cur_mode) + (cur_len + 1) * bpb(cur_mode));
                spi_io0_i = 1'b0; spi_io1_i = 1'b0; gap = 0;
            end
            if (spi_cs_n) gap++;
            // Rising serial clock: the flash samples the controller's pins.
            if (!spi_cs_n && !prev_sclk && spi_sclk) begin
                int k;
                k = nr;
                nr++;
                if (k < 8) begin
                    chk(spi_io0_oe && !spi_io1_oe, "R2 command pins", {spi_io1_oe, spi_io0_oe}, 1);
                    opc = {opc[6:0], spi_io0_o};
                    if (k == 7) chk(opc == exp_opc(cur_mode), "R2 command byte", opc, exp_opc(cur_mode));
                end else if (k < 8 + addr_clks(cur_mode)) begin
                    if (is_dual(cur_mode)) begin
                        chk(spi_io0_oe && spi_io1_oe, "R3 two-pin address enables", {spi_io1_oe, spi_io0_oe}, 3);
                        arx = {arx[21:0], spi_io1_o, spi_io0_o};
                    end else begin
                        chk(spi_io0_oe && !spi_io1_oe, "R3 address enables", {spi_io1_oe, spi_io0_oe}, 1);
                        arx = {arx[22:0], spi_io0_o};
                    end
                    if (k == 8 + addr_clks(cur_mode) - 1) chk(arx == cur_addr, "R3 address value", arx, cur_addr);
                end else if (k < hdr_clks(cur_mode)) begin
                    if (is_dual(cur_mode)) chk(!spi_io0_oe && !spi_io1_oe, "R5 released in idle clocks", {spi_io1_oe, spi_io0_oe}, 0);
                    else chk(spi_io0_oe && !spi_io1_oe, "R4 fast idle drive", {spi_io1_oe, spi_io0_oe}, 1);
                end else begin
                    if (is_dual(cur_mode)) chk(!spi_io0_oe && !spi_io1_oe, "R5 released in data", {spi_io1_oe, spi_io0_oe}, 0);
                    else chk(!spi_io1_oe, "R7 data pin not driven", spi_io1_oe, 0);
                    if ((k - hdr_clks(cur_mode)) % bpb(cur_mode) == 0)
                        chk(!prev_vnr, "R10 byte start while output held", prev_vnr, 0);
                end
            end
            // Falling serial clock: the flash drives its next data bit(s).
            if (!spi_cs_n && prev_sclk && !spi_sclk && nr >= hdr_clks(cur_mode)) begin
                int d, bi, bt;
                logic [7:0] v;
                d  = nr - hdr_clks(cur_mode);
                bi = d / bpb(cur_mode);
                bt = d % bpb(cur_mode);
                v  = mem_byte(cur_addr + 24'(bi));
                if (is_dual(cur_mode)) begin
                    spi_io1_i = v[7 - 2 * bt];
                    spi_io0_i = v[6 - 2 * bt];
                end else begin
                    spi_io1_i = v[7 - bt];
                end
            end
            prev_cs   = spi_cs_n;
            prev_sclk = spi_sclk;
            prev_vnr  = dout_valid && !dout_ready;
        end
    end

    task automatic do_req(input int m, input logic [23:0] a, input int l);
        while (busy) @(negedge clk);
        cur_mode = m; cur_addr = a; cur_len = l;
        for (int i = 0; i <= l; i++) exp_q.push_back(mem_byte(a + 24'(i)));
        req_mode = 2'(m); req_addr = a; req_len_m1 = 16'(l); req_valid = 1'b1;
        ntx_exp++;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy || exp_q.size() != 0 || dout_valid) @(negedge clk);
    endtask

    task automatic try_busy();
        while (!busy) @(negedge clk);
        chk(req_ready == 1'b0, "R11 ready low while busy", req_ready, 0);
        req_valid = 1'b1; req_addr = 24'h555555; req_mode = 2'd2; req_len_m1 = '0;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R1 reset chip select", spi_cs_n, 1);
        chk(spi_sclk == 1'b0, "R1 reset clock", spi_sclk, 0);
        chk(busy == 1'b0, "R1 reset busy", busy, 0);
        chk(dout_valid == 1'b0, "R1 reset output", dout_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!spi_io0_oe && !spi_io1_oe, "R1 idle enables", {spi_io1_oe, spi_io0_oe}, 0);
        // Each mode with distinct patterns (R2 R3 R4 R5 R7 R8).
        do_req(0, 24'h123456, 3);  wait_idle();
        do_req(1, 24'h00ABCD, 2);  wait_idle();
        do_req(2, 24'h8001F0, 4);  wait_idle();
        do_req(3, 24'h0F0F0F, 0);  wait_idle();
        // Spans across the top address (R12).
        do_req(2, 24'hFFFFFE, 3);  wait_idle();
        do_req(0, 24'hFFFFFF, 2);  wait_idle();
        do_req(1, 24'hFFFFFD, 5);  wait_idle();
        // Backpressure and back-to-back requests (R9 R10).
        bp_on = 1'b1;
        do_req(0, 24'h3A5C00, 5);
        do_req(2, 24'h77E001, 7);
        do_req(1, 24'h000010, 4);
        wait_idle();
        bp_on = 1'b0;
        // Request offered while busy is dropped (R11).
        do_req(1, 24'h0000F0, 3);
        try_busy();
        wait_idle();
        repeat (10) @(negedge clk);
        chk(txn == ntx_exp, "R11 transaction count", txn, ntx_exp);
        chk(exp_q.size() == 0, "R8 all bytes delivered", exp_q.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule